// File: doc/BRIEF.md
# DRAM refresh row address extender

A processor with built-in dynamic memory support emits a refresh row address during each of its refresh cycles, but that address is only seven bits wide. A 64K x 1 dynamic RAM with 256 refresh rows needs eight. This block watches the processor's refresh strobes and keeps a small extension count beside the processor's row counter. The count advances each time the seven-bit counter rolls over. The full row address is the extension bits placed above the processor's bits.

Refresh only happens while the processor owns the bus, so the extension only moves on genuine refresh cycles. A strobe that does not carry a memory request is ignored. For parts that refresh with seven row bits, a strap forces the extension bits on the output to zero. The count itself keeps running underneath the strap. Only a synchronous power-on reset clears the extension. The front-panel reset is expected to arrive at the processor as a non-maskable interrupt, so it never reaches this block and refresh keeps running through it.

All pins are plain control and address levels. There is no stream interface and no back-pressure. The output is valid in every cycle, and the memory samples it during refresh.

Top module: `refresh_row_ext`

## Requirements
- R1: The low seven bits of `ref_row` equal `cpu_row` in every cycle, whether or not a refresh is in progress.
- R2: A refresh cycle is recognised only while `rfsh_n` and `mreq_n` are both low. One unbroken low interval counts as one refresh cycle, however many clocks it lasts.
- R3: When a recognised refresh cycle carries address 0x00 and the previous recognised one carried 0x7F, the extension (bit 7 of `ref_row`) advances by one, which toggles it. The new value shows from the first clock of that cycle. Any other address change leaves the extension unchanged.
- R4: While `short_rows` is 1, bit 7 of `ref_row` is 0. The extension count keeps advancing underneath, and its true value appears once the strap returns to 0.
- R5: Between recognised refresh cycles the extension holds its value. A strobe with `mreq_n` high neither advances it nor replaces the remembered previous address.
- R6: A synchronous reset (`rst_n` low at a clock edge) clears the extension to 0 and forgets the previous address. The first refresh cycle after reset therefore never advances the extension, even if it carries 0x00.
- R7: From reset, 256 consecutive refresh cycles that walk the processor's rows 0x00..0x7F twice present every row 0..255 exactly once, in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rfsh_n | input | 1 | Processor refresh strobe, active low |
| mreq_n | input | 1 | Processor memory request, active low |
| cpu_row | input | 7 | Processor refresh row address |
| short_rows | input | 1 | Strap: 1 selects 128-row parts and forces the extension bit on the output to 0 |
| ref_row | output | 8 | Full refresh row address for the memory |

## Verification
The main pattern is a full double sweep of the processor's rows. It shows that the 0x7F to 0x00 rollover, and nothing else, toggles the upper bit, and that all 256 rows come out once in order. Downward jumps to 0x00 from other rows separate a true rollover detector from a plain zero detector. Strobes with the memory request high separate genuine refresh from a lone strobe. A refresh held low for several clocks separates edge counting from level counting. Strap and mid-run reset sequences show that the strap masks only the output, and that reset forgets the remembered previous row.

// File: rtl/refresh_row_ext_pkg.sv
package refresh_row_ext_pkg;

  // Highest value of a row counter of the given width.
  function automatic logic [15:0] row_max(input int unsigned w);
    row_max = 16'((32'd1 << w) - 32'd1);
  endfunction

  // Detector states.
  typedef enum logic [1:0] {
    RFX_IDLE   = 2'd0,
    RFX_ACTIVE = 2'd1
  } rfx_phase_e;

endpackage

// File: rtl/rfx_strobe_detect.sv
module rfx_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_n,
  input  logic mreq_n,
  output logic active,
  output logic start
);
  import refresh_row_ext_pkg::*;

  rfx_phase_e phase_q;

  assign active = !rfsh_n && !mreq_n;
  assign start  = active && (phase_q == RFX_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= RFX_IDLE;
    end else begin
      phase_q <= active ? RFX_ACTIVE : RFX_IDLE;
    end
  end
endmodule

// File: rtl/rfx_wrap_detect.sv
module rfx_wrap_detect #(
  parameter int unsigned CPU_ROW_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CPU_ROW_W-1:0] cpu_row,
  output logic                 wrap_now
);
  import refresh_row_ext_pkg::*;

  localparam logic [CPU_ROW_W-1:0] ROW_TOP = CPU_ROW_W'(row_max(CPU_ROW_W));

  logic [CPU_ROW_W-1:0] last_q;
  logic                 seen_q;

  assign wrap_now = start && seen_q && (last_q == ROW_TOP) && (cpu_row == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (start) begin
      last_q <= cpu_row;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rfx_ext_counter.sv
module rfx_ext_counter #(
  parameter int unsigned EXT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_now,
  output logic [EXT_W-1:0] ext_now
);
  logic [EXT_W-1:0] ext_q;
  logic [EXT_W-1:0] ext_next;

  generate
    if (EXT_W == 1) begin : g_toggle
      assign ext_next = ext_q ^ wrap_now;
    end else begin : g_count
      assign ext_next = ext_q + EXT_W'(wrap_now);
    end
  endgenerate

  // The value used during the cycle that causes the advance is already the new one.
  assign ext_now = ext_next;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_next;
  end
endmodule

// File: rtl/refresh_row_ext.sv
module refresh_row_ext #(
  parameter int unsigned CPU_ROW_W = 7,
  parameter int unsigned EXT_W     = 1,
  localparam int unsigned ROW_W    = CPU_ROW_W + EXT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rfsh_n,
  input  logic                 mreq_n,
  input  logic [CPU_ROW_W-1:0] cpu_row,
  input  logic                 short_rows,
  output logic [ROW_W-1:0]     ref_row
);
  logic             active;
  logic             start;
  logic             wrap_now;
  logic [EXT_W-1:0] ext_now;

  rfx_strobe_detect u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .rfsh_n (rfsh_n),
    .mreq_n (mreq_n),
    .active (active),
    .start  (start)
  );

  rfx_wrap_detect #(.CPU_ROW_W(CPU_ROW_W)) u_wrap (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cpu_row  (cpu_row),
    .wrap_now (wrap_now)
  );

  rfx_ext_counter #(.EXT_W(EXT_W)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_now (wrap_now),
    .ext_now  (ext_now)
  );

  assign ref_row = {(short_rows ? {EXT_W{1'b0}} : ext_now), cpu_row};
endmodule

// File: rtl/refresh_row_ext_chk.sv
module refresh_row_ext_chk #(
  parameter int unsigned CPU_ROW_W = 7,
  parameter int unsigned EXT_W     = 1,
  localparam int unsigned ROW_W    = CPU_ROW_W + EXT_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rfsh_n,
  input logic                 mreq_n,
  input logic [CPU_ROW_W-1:0] cpu_row,
  input logic                 short_rows,
  input logic [ROW_W-1:0]     ref_row
);
  localparam logic [CPU_ROW_W-1:0] TOP = {CPU_ROW_W{1'b1}};

  logic                 act;
  logic                 act_q;
  logic                 begin_c;
  logic [CPU_ROW_W-1:0] prev_q;
  logic                 have_q;
  logic                 roll_c;
  logic [EXT_W-1:0]     ext_o;

  assign act     = !rfsh_n && !mreq_n;
  assign begin_c = act && !act_q;
  assign roll_c  = begin_c && have_q && (prev_q == TOP) && (cpu_row == '0);
  assign ext_o   = ref_row[ROW_W-1:CPU_ROW_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      prev_q <= '0;
      have_q <= 1'b0;
    end else begin
      act_q <= act;
      if (begin_c) begin
        prev_q <= cpu_row;
        have_q <= 1'b1;
      end
    end
  end

  // R1
  a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ref_row[CPU_ROW_W-1:0] == cpu_row);

  // R4
  a_r4_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
    short_rows |-> (ext_o == '0));

  // R5: outside refresh, with the strap steady at 0, the extension holds
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !short_rows) |=> (short_rows || begin_c || ext_o == $past(ext_o)));

  // R2: later clocks of one refresh interval do not move the extension
  a_r2_single_count: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !short_rows) |=> ((act && !begin_c && !short_rows) -> ext_o == $past(ext_o)));

  // R3: a rollover advances by exactly one
  a_r3_roll_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_rows) |=> ((roll_c && !short_rows) -> ext_o == $past(ext_o) + 1'b1));

  // R3: any other refresh start keeps the value
  a_r3_other_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!short_rows) |=> ((begin_c && !roll_c && !short_rows) -> ext_o == $past(ext_o)));
endmodule

bind refresh_row_ext refresh_row_ext_chk #(.CPU_ROW_W(CPU_ROW_W), .EXT_W(EXT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rfsh_n     (rfsh_n),
  .mreq_n     (mreq_n),
  .cpu_row    (cpu_row),
  .short_rows (short_rows),
  .ref_row    (ref_row)
);

// File: tb/refresh_row_ext_tb_top.sv
`timescale 1ns/1ps
module refresh_row_ext_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rfsh_n = 1'b1;
  logic       mreq_n = 1'b1;
  logic [6:0] cpu_row = 7'h00;
  logic       short_rows = 1'b0;
  logic [7:0] ref_row;

  int errors = 0;
  int checks = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model of the requirements
  logic       m_ext = 1'b0;
  logic [6:0] m_last = 7'h00;
  logic       m_have = 1'b0;
  bit         seen[256];
  bit         track = 1'b0;

  always #5 clk = ~clk;

  refresh_row_ext dut_i (
    .clk(clk), .rst_n(rst_n), .rfsh_n(rfsh_n), .mreq_n(mreq_n),
    .cpu_row(cpu_row), .short_rows(short_rows), .ref_row(ref_row)
  );

  task automatic check(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: ref_row=%02h expected=%02h", tag, act_v, exp_v);
    end
  endtask

  // monitor: one expected item per clock of a genuine refresh
  always @(negedge clk) begin
    if (rst_n && !rfsh_n && !mreq_n) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected refresh", ref_row, 8'hxx);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, ref_row, e);
        if (track) begin
          checks++;
          if (seen[ref_row]) begin
            errors++;
            $display("FAIL R7: row %02h repeated, expected first visit", ref_row);
          end
          seen[ref_row] = 1'b1;
        end
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; rfsh_n = 1'b1; mreq_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_ext = 1'b0; m_have = 1'b0; m_last = 7'h00;
  endtask

  // one refresh of ncyc clocks; genuine selects whether mreq_n goes low
  task automatic refresh(input logic [6:0] a, input int ncyc, input bit genuine, input string tag);
    @(posedge clk); #1;
    cpu_row = a;
    rfsh_n = 1'b0;
    mreq_n = genuine ? 1'b0 : 1'b1;
    if (genuine) begin
      if (m_have && m_last == 7'h7F && a == 7'h00) m_ext = ~m_ext;
      m_last = a;
      m_have = 1'b1;
      for (int k = 0; k < ncyc; k++) begin
        exp_q.push_back({short_rows ? 1'b0 : m_ext, a});
        tag_q.push_back(tag);
      end
    end
    repeat (ncyc) @(posedge clk);
    #1 rfsh_n = 1'b1; mreq_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    cpu_row = 7'h55;
    @(negedge clk);
    check("R6 reset state", ref_row, 8'h55);

    // R7 and R3: double sweep from reset
    track = 1'b1;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 128; i++) refresh(7'(i), 1, 1'b1, "R7 sweep");
    @(posedge clk); @(negedge clk);
    track = 1'b0;
    for (int r = 0; r < 256; r++) begin
      checks++;
      if (!seen[r]) begin
        errors++;
        $display("FAIL R7: row %02h missing, expected present", r);
      end
    end

    // R3: next rollover returns to 0
    refresh(7'h00, 1, 1'b1, "R3 third wrap");
    refresh(7'h01, 1, 1'b1, "R3 after wrap");

    // R3: jump to 0 from a non-top row does not advance
    refresh(7'h0A, 1, 1'b1, "R3 pre jump");
    refresh(7'h00, 1, 1'b1, "R3 non-wrap jump");
    refresh(7'h7E, 1, 1'b1, "R3 near top");
    refresh(7'h00, 1, 1'b1, "R3 from 7E");

    // R5: strobes with mreq_n high are ignored
    refresh(7'h7F, 1, 1'b1, "R5 top");
    refresh(7'h00, 1, 1'b0, "R5 fake");
    @(negedge clk);
    check("R5 idle hold", ref_row, {m_ext, 7'h00});
    refresh(7'h05, 1, 1'b1, "R5 after fake");
    refresh(7'h00, 1, 1'b1, "R5 no wrap 05");

    // R2: long refresh counts once
    refresh(7'h7F, 2, 1'b1, "R2 top long");
    refresh(7'h00, 3, 1'b1, "R2 long wrap");
    refresh(7'h01, 1, 1'b1, "R2 single advance");

    // R4: strap masks output, count still runs
    short_rows = 1'b1;
    refresh(7'h7F, 1, 1'b1, "R4 strap top");
    refresh(7'h00, 1, 1'b1, "R4 strap wrap");
    refresh(7'h7F, 1, 1'b1, "R4 strap top2");
    refresh(7'h00, 1, 1'b1, "R4 strap wrap2");
    refresh(7'h7F, 1, 1'b1, "R4 strap top3");
    refresh(7'h00, 1, 1'b1, "R4 strap wrap3");
    @(posedge clk); #1 short_rows = 1'b0;
    refresh(7'h01, 1, 1'b1, "R4 strap released");

    // R6: reset mid-run after row 7F; next 00 must not advance
    if (!m_ext) begin
      refresh(7'h7F, 1, 1'b1, "R6 prep top");
      refresh(7'h00, 1, 1'b1, "R6 prep wrap");
    end
    refresh(7'h7F, 1, 1'b1, "R6 top before reset");
    do_reset();
    cpu_row = 7'h7F;
    @(negedge clk);
    check("R6 cleared", ref_row, 8'h7F);
    refresh(7'h00, 1, 1'b1, "R6 first after reset");
    refresh(7'h01, 1, 1'b1, "R6 second after reset");

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d expected items left, expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule